// File: doc/BRIEF.md
# Fuse Array Burst Read Controller

This block reads a one-time-programmable fuse array of 8192 bits (1024 bytes) through a small 32-bit register interface. Software loads a byte start address and a transfer length into the control word and sets its read bit. The controller then walks the fuse array one byte at a time. For every byte it drives the address and a read strobe, using setup and strobe durations counted in bus clocks and taken from the configuration word. The fetched bytes are packed into a bank of eight 32-bit data words, which holds at most 32 bytes. When the last byte of the burst has landed, a read-done status bit rises.

In normal use software programs the timing fields once after reset. It then issues reads of up to 32 bytes from 32-byte-aligned start addresses, polls the done bit, and collects the result from the data words. Programming the fuses is not supported: the write and program enable bits are kept as plain storage. The fuse macro sits outside the block on a byte-wide port. A synthesizable ROM stand-in with computed content takes its place in the bench.

Top module: `fuse_rd_ctrl`

## Requirements
- R1: Word offsets on the bus: control at 0x00, configuration at 0x04, status at 0x08, and data word n (n = 0..7) at 0x0C + 4n. All of these read zero after reset.
- R2: The control word holds the byte start address in bits 30:21 and the byte count minus one in bits 20:16. It also holds a program-enable bit at bit 15, a write-enable bit at bit 1 and a read-enable bit at bit 0. All of them read back as written, and every other bit reads 0.
- R3: The configuration word holds interrupt-enable at bit 31, read setup count at bits 23:20, read strobe count at bits 19:16, write setup count at bits 15:12 and write strobe count at bits 11:0. Bits 30:24 read 0.
- R4: Each byte access lasts setup + 5 + strobe clocks. The read strobe is low for the first setup + 1 clocks and high for the rest of the access. The fuse byte is sampled on the last clock of the access.
- R5: A control write with bit 0 set while idle starts a burst and clears read-done (status bit 0) on the next clock. For an N-byte burst, read-done first reads 1 exactly N × (setup + 5 + strobe) clocks after the starting write edge. Bit 0 of the control word then reads 0, and read-done stays 1 until the next start.
- R6: Control writes made while a burst is running are ignored. Neither the fields nor the burst are changed.
- R7: Byte k of a burst is read from fuse address start + k. It lands in data word k/4 at bits 8·(k mod 4)+7 down to 8·(k mod 4).
- R8: Starting a burst clears all data words, so bytes past the programmed length read 0.
- R9: Setting write-enable or program-enable without read-enable starts nothing. No strobe is issued, read-done stays 0 and status bit 1 (write-done) always reads 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Register access select |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 6 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational, 0 when not selected |
| fuse_addr | output | 10 | Byte address to the fuse array |
| fuse_strobe | output | 1 | Read strobe to the fuse array |
| fuse_data | input | 8 | Byte returned by the fuse array |

## Verification
Bursts are run with several setup/strobe pairs: both zero, small unequal values, both at the 4-bit maximum, and a single-byte burst. The cycle where the strobe first rises and the cycle where read-done first appears are compared with the formula, which separates off-by-one faults in the setup phase from faults in the per-byte period. Full 32-byte bursts at different aligned addresses, followed by short bursts, show both the little-endian packing and the clearing of stale bytes. The ROM stand-in drives data only while the strobe is high, so sampling before the strobe phase returns wrong bytes. A control write during a burst and a write-only/program-only control value show that those inputs change nothing.

// File: rtl/fuse_rd_pkg.sv
package fuse_rd_pkg;
   // word indices on the register bus
   localparam int unsigned IDX_CTRL  = 0;
   localparam int unsigned IDX_CFG   = 1;
   localparam int unsigned IDX_STAT  = 2;
   localparam int unsigned IDX_DATA0 = 3;

   // control word field positions
   localparam int unsigned CTL_ADDR_LSB = 21;
   localparam int unsigned CTL_LEN_LSB  = 16;
   localparam int unsigned CTL_PG_BIT   = 15;
   localparam int unsigned CTL_WR_BIT   = 1;
   localparam int unsigned CTL_RD_BIT   = 0;

   // configuration word field positions
   localparam int unsigned CFG_IEN_BIT  = 31;
   localparam int unsigned CFG_RADJ_LSB = 20;
   localparam int unsigned CFG_RSTR_LSB = 16;
   localparam int unsigned CFG_WADJ_LSB = 12;
   localparam int unsigned CFG_WSTR_LSB = 0;
   localparam int unsigned CFG_WSTR_W   = 12;
   localparam int unsigned CFG_WADJ_W   = 4;

   localparam int unsigned BYTES_PER_WORD = 4;
endpackage

// File: rtl/fuse_rom_model.sv
module fuse_rom_model #(
   parameter int unsigned ADDR_W = 10
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic              strobe,
   output logic [7:0]        data
);
   logic [7:0] mix;

   always_comb begin
      mix  = (addr[7:0] * 8'd29) ^ 8'(addr >> 4) ^ 8'h5A;
      data = strobe ? mix : 8'h00;
   end
endmodule

// File: rtl/fuse_rd_timer.sv
module fuse_rd_timer #(
   parameter int unsigned ADJ_W = 4,
   parameter int unsigned STR_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic [ADJ_W-1:0] adj,
   input  logic [STR_W-1:0] str,
   output logic             strobe,
   output logic             last
);
   localparam int unsigned CNT_W = ((ADJ_W > STR_W) ? ADJ_W : STR_W) + 2;

   logic [CNT_W-1:0] cnt;
   logic [CNT_W-1:0] span_m1;

   assign span_m1 = CNT_W'(adj) + CNT_W'(str) + CNT_W'(4);
   assign last    = run && (cnt == span_m1);
   assign strobe  = run && (cnt > CNT_W'(adj));

   always_ff @(posedge clk) begin
      if (!rst_n)           cnt <= '0;
      else if (!run || last) cnt <= '0;
      else                  cnt <= cnt + 1'b1;
   end

   // capture happens only inside the strobe phase
   p_last_in_strobe_r4: assert property (@(posedge clk) disable iff (!rst_n)
      last |-> strobe);
   // strobe rises exactly after setup + 1 clocks
   p_setup_len_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(strobe) |-> (cnt == CNT_W'(adj) + 1'b1));
endmodule

// File: rtl/fuse_rd_bank.sv
module fuse_rd_bank #(
   parameter int unsigned NUM_WORDS = 8,
   parameter int unsigned IDX_W     = 5
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    clr,
   input  logic                    we,
   input  logic [IDX_W-1:0]        idx,
   input  logic [7:0]              byte_in,
   output logic [NUM_WORDS*32-1:0] words
);
   localparam int unsigned SEL_W = IDX_W - 2;

   generate
      for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
         logic [31:0] word_q;
         always_ff @(posedge clk) begin
            if (!rst_n || clr)
               word_q <= '0;
            else if (we && (idx[IDX_W-1:2] == SEL_W'(w)))
               word_q[8*idx[1:0] +: 8] <= byte_in;
         end
         assign words[32*w +: 32] = word_q;
      end
   endgenerate

   p_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (words == '0));
   p_clr_we_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !(clr && we));
endmodule

// File: rtl/fuse_rd_ctrl.sv
module fuse_rd_ctrl
   import fuse_rd_pkg::*;
#(
   parameter int unsigned ADDR_W    = 10,
   parameter int unsigned LEN_W     = 5,
   parameter int unsigned NUM_WORDS = 8,
   parameter int unsigned ADJ_W     = 4,
   parameter int unsigned STR_W     = 4,
   parameter int unsigned BUS_AW    = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_sel,
   input  logic              bus_wr,
   input  logic [BUS_AW-1:0] bus_addr,
   input  logic [31:0]       bus_wdata,
   output logic [31:0]       bus_rdata,
   output logic [ADDR_W-1:0] fuse_addr,
   output logic              fuse_strobe,
   input  logic [7:0]        fuse_data
);
   localparam int unsigned WIDX_W = BUS_AW - 2;

   generate
      if (NUM_WORDS * BYTES_PER_WORD != (1 << LEN_W))
         $error("data bank must hold exactly one maximum burst");
      if (CTL_ADDR_LSB + ADDR_W > 31)
         $error("start address field does not fit the control word");
      if (ADJ_W != 4 || STR_W != 4)
         $error("read timing fields are 4 bits wide in the configuration word");
      if ((IDX_DATA0 + NUM_WORDS) > (1 << WIDX_W))
         $error("bus offset too narrow for the register map");
   endgenerate

   logic [WIDX_W-1:0] widx;
   logic              wr_any, ctrl_wr, cfg_wr, start;

   logic [ADDR_W-1:0]     start_q;
   logic [LEN_W-1:0]      len_q;
   logic                  pg_q, wren_q, busy_q, done_q;
   logic                  ien_q;
   logic [ADJ_W-1:0]      radj_q, radj_run;
   logic [STR_W-1:0]      rstr_q, rstr_run;
   logic [CFG_WADJ_W-1:0] wadj_q;
   logic [CFG_WSTR_W-1:0] wstr_q;
   logic [LEN_W-1:0]      idx_q;
   logic                  acc_last;
   logic [NUM_WORDS*32-1:0] words;

   assign widx    = bus_addr[BUS_AW-1:2];
   assign wr_any  = bus_sel && bus_wr;
   assign ctrl_wr = wr_any && (widx == WIDX_W'(IDX_CTRL)) && !busy_q;
   assign cfg_wr  = wr_any && (widx == WIDX_W'(IDX_CFG));
   assign start   = ctrl_wr && bus_wdata[CTL_RD_BIT];

   // register writes
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         start_q <= '0;  len_q  <= '0;  pg_q   <= 1'b0; wren_q <= 1'b0;
         ien_q   <= 1'b0; radj_q <= '0; rstr_q <= '0;  wadj_q <= '0;
         wstr_q  <= '0;
      end else begin
         if (ctrl_wr) begin
            start_q <= bus_wdata[CTL_ADDR_LSB +: ADDR_W];
            len_q   <= bus_wdata[CTL_LEN_LSB  +: LEN_W];
            pg_q    <= bus_wdata[CTL_PG_BIT];
            wren_q  <= bus_wdata[CTL_WR_BIT];
         end
         if (cfg_wr) begin
            ien_q  <= bus_wdata[CFG_IEN_BIT];
            radj_q <= bus_wdata[CFG_RADJ_LSB +: ADJ_W];
            rstr_q <= bus_wdata[CFG_RSTR_LSB +: STR_W];
            wadj_q <= bus_wdata[CFG_WADJ_LSB +: CFG_WADJ_W];
            wstr_q <= bus_wdata[CFG_WSTR_LSB +: CFG_WSTR_W];
         end
      end
   end

   // burst sequencer
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy_q <= 1'b0; done_q <= 1'b0; idx_q <= '0;
         radj_run <= '0; rstr_run <= '0;
      end else if (start) begin
         busy_q   <= 1'b1;
         done_q   <= 1'b0;
         idx_q    <= '0;
         radj_run <= radj_q;
         rstr_run <= rstr_q;
      end else if (acc_last) begin
         if (idx_q == len_q) begin
            busy_q <= 1'b0;
            done_q <= 1'b1;
         end else begin
            idx_q <= idx_q + 1'b1;
         end
      end
   end

   fuse_rd_timer #(.ADJ_W(ADJ_W), .STR_W(STR_W)) u_timer (
      .clk    (clk),
      .rst_n  (rst_n),
      .run    (busy_q),
      .adj    (radj_run),
      .str    (rstr_run),
      .strobe (fuse_strobe),
      .last   (acc_last)
   );

   fuse_rd_bank #(.NUM_WORDS(NUM_WORDS), .IDX_W(LEN_W)) u_bank (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr     (start),
      .we      (acc_last),
      .idx     (idx_q),
      .byte_in (fuse_data),
      .words   (words)
   );

   assign fuse_addr = start_q + ADDR_W'(idx_q);

   // register read
   always_comb begin
      bus_rdata = '0;
      if (bus_sel && !bus_wr) begin
         if (widx == WIDX_W'(IDX_CTRL)) begin
            bus_rdata[CTL_ADDR_LSB +: ADDR_W] = start_q;
            bus_rdata[CTL_LEN_LSB  +: LEN_W]  = len_q;
            bus_rdata[CTL_PG_BIT]             = pg_q;
            bus_rdata[CTL_WR_BIT]             = wren_q;
            bus_rdata[CTL_RD_BIT]             = busy_q;
         end else if (widx == WIDX_W'(IDX_CFG)) begin
            bus_rdata[CFG_IEN_BIT]                 = ien_q;
            bus_rdata[CFG_RADJ_LSB +: ADJ_W]       = radj_q;
            bus_rdata[CFG_RSTR_LSB +: STR_W]       = rstr_q;
            bus_rdata[CFG_WADJ_LSB +: CFG_WADJ_W]  = wadj_q;
            bus_rdata[CFG_WSTR_LSB +: CFG_WSTR_W]  = wstr_q;
         end else if (widx == WIDX_W'(IDX_STAT)) begin
            bus_rdata[0] = done_q;
         end else begin
            for (int w = 0; w < NUM_WORDS; w++)
               if (widx == WIDX_W'(IDX_DATA0 + w))
                  bus_rdata = words[32*w +: 32];
         end
      end
   end

   p_start_clears_done_r5: assert property (@(posedge clk) disable iff (!rst_n)
      start |=> (busy_q && !done_q));
   p_busy_write_ignored_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_q && wr_any && widx == WIDX_W'(IDX_CTRL)) |=>
         ($stable(start_q) && $stable(len_q) && $stable(pg_q)));
   p_strobe_needs_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
      fuse_strobe |-> busy_q);
   p_idx_in_range_r7: assert property (@(posedge clk) disable iff (!rst_n)
      busy_q |-> (idx_q <= len_q));
   p_done_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (done_q && !start) |=> done_q);
endmodule

// File: tb/test_fuse_rd_ctrl.sv
module test_fuse_rd_ctrl;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_sel = 1'b0, bus_wr = 1'b0;
   logic [5:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic [9:0]  fuse_addr;
   logic        fuse_strobe;
   logic [7:0]  fuse_data;

   int checks = 0;
   int errors = 0;
   bit finished = 1'b0;

   always #4 clk = ~clk;

   fuse_rd_ctrl i_fuse_rd_ctrl (
      .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .fuse_addr(fuse_addr), .fuse_strobe(fuse_strobe), .fuse_data(fuse_data)
   );

   fuse_rom_model i_rom (.addr(fuse_addr), .strobe(fuse_strobe), .data(fuse_data));

   function automatic logic [7:0] ref_byte(input int a);
      logic [9:0] aa;
      aa = 10'(a);
      return (aa[7:0] * 8'd29) ^ 8'(aa >> 4) ^ 8'h5A;
   endfunction

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   // called at a negedge, returns at the following negedge
   task automatic bus_write(input logic [5:0] a, input logic [31:0] d);
      bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(posedge clk);
      @(negedge clk);
      bus_sel = 1'b0; bus_wr = 1'b0;
   endtask

   task automatic bus_read(input logic [5:0] a, output logic [31:0] d);
      bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
      #1 d = bus_rdata;
      bus_sel = 1'b0;
   endtask

   function automatic logic [31:0] ctrl_val(int start, int len, bit pg, bit wr, bit rd);
      return (32'(start) << 21) | (32'(len) << 16) | (32'(pg) << 15) | (32'(wr) << 1) | 32'(rd);
   endfunction

   task automatic t_reset;
      logic [31:0] v;
      for (int r = 0; r < 11; r++) begin
         bus_read(6'(4 * r), v);
         check("R1 reset value", v, 32'h0);
      end
   endtask

   task automatic t_cfg_fields;
      logic [31:0] v;
      bus_write(6'h04, 32'hFFFF_FFFF);
      bus_read(6'h04, v);
      check("R3 config all-ones readback", v, 32'h80FF_FFFF);
      bus_write(6'h04, 32'h8012_3ABC);
      bus_read(6'h04, v);
      check("R3 config pattern readback", v, 32'h8012_3ABC);
   endtask

   task automatic t_no_action;
      logic [31:0] v;
      bit saw_strobe = 1'b0;
      bus_write(6'h00, ctrl_val(5, 3, 1, 1, 0));
      bus_read(6'h00, v);
      check("R2 control fields readback", v, ctrl_val(5, 3, 1, 1, 0));
      for (int c = 0; c < 60; c++) begin
         if (fuse_strobe) saw_strobe = 1'b1;
         @(negedge clk);
      end
      check("R9 no strobe without read enable", 32'(saw_strobe), 32'h0);
      bus_read(6'h08, v);
      check("R9 status stays clear", v, 32'h0);
   endtask

   task automatic t_burst(input int adj, input int str, input int start, input int len);
      logic [31:0] v, exp;
      int t, n, rise_c, done_c;
      t = adj + 5 + str;
      n = len + 1;
      rise_c = -1; done_c = -1;
      bus_write(6'h04, (32'(adj) << 20) | (32'(str) << 16));
      bus_write(6'h00, ctrl_val(start, len, 0, 0, 1));
      // now at cycle 0 of the burst
      bus_read(6'h08, v);
      check("R5 done cleared by start", v, 32'h0);
      for (int c = 0; c <= n * t + 2; c++) begin
         if (fuse_strobe && rise_c < 0) rise_c = c;
         bus_read(6'h08, v);
         if (v[0] && done_c < 0) done_c = c;
         @(negedge clk);
      end
      check($sformatf("R4 strobe rise adj=%0d", adj), 32'(rise_c), 32'(adj + 1));
      check($sformatf("R5 done cycle adj=%0d str=%0d n=%0d", adj, str, n),
            32'(done_c), 32'(n * t));
      bus_read(6'h00, v);
      check("R5 read enable self-clears", v, ctrl_val(start, len, 0, 0, 0));
      bus_read(6'h08, v);
      check("R5 done sticky", v, 32'h1);
      for (int w = 0; w < 8; w++) begin
         for (int b = 0; b < 4; b++) begin
            int k = 4 * w + b;
            exp[8*b +: 8] = (k <= len) ? ref_byte(start + k) : 8'h00;
         end
         bus_read(6'(12 + 4 * w), v);
         check($sformatf("R7 R8 data word %0d", w), v, exp);
      end
   endtask

   task automatic t_busy_write;
      logic [31:0] v, exp;
      int start = 64;
      bus_write(6'h04, 32'h0010_0000);
      bus_write(6'h00, ctrl_val(start, 31, 0, 0, 1));
      repeat (3) @(negedge clk);
      bus_write(6'h00, ctrl_val(200, 2, 1, 0, 1));
      bus_read(6'h00, v);
      check("R6 control unchanged during burst", v, ctrl_val(start, 31, 0, 0, 1));
      repeat (250) @(negedge clk);
      bus_read(6'h08, v);
      check("R6 burst completes", v, 32'h1);
      for (int w = 0; w < 8; w++) begin
         for (int b = 0; b < 4; b++) exp[8*b +: 8] = ref_byte(start + 4 * w + b);
         bus_read(6'(12 + 4 * w), v);
         check($sformatf("R6 data word %0d", w), v, exp);
      end
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_cfg_fields();
      t_no_action();
      t_burst(0, 0, 0, 31);
      t_burst(3, 2, 32, 31);
      t_burst(15, 15, 992, 7);
      t_burst(1, 0, 96, 0);
      t_busy_write();
      if (!finished) begin
         finished = 1'b1;
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         finished = 1'b1;
         checks++; errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule